// File: doc/BRIEF.md
# Periodic Thermal Trip Controller

This block watches a digital die-temperature code and turns it into three trip flags: catastrophic, hot and auxiliary. In thermometer mode an interval timer counts clock cycles and, once per programmed interval, samples the temperature code. It compares the sample against three programmed thresholds. A one-cycle sample-valid pulse marks each sample, and the trip flags change only on that pulse. Once a flag is set, the threshold it must fall below is lowered by a programmable digital hysteresis amount, so a reading that hovers near a threshold does not make the flag chatter.

When the rate field selects no valid interval, the block works in analog mode. It takes a single comparator bit from an external analog sensor and routes it to the catastrophic or the hot flag, according to a select input. Clearing the rate field while a measurement interval is running does not cut that interval short: the interval completes and reports its sample first. Dropping the sensor enable stops the timer and clears every flag.

Top module: `thermal_trip_ctrl`

## Requirements
- R1: Rate codes 1 to 7 give sampling intervals of 512, 1024, 1536, 2048, 3072, 4096 and 6144 clocks. `sample_valid` is high for exactly one cycle. The first pulse rises P+1 rising edges after a valid code reaches an idle timer, and later pulses follow every P cycles.
- R2: Rate code 15 gives a 4-clock interval for testing.
- R3: Rate code 0 and the reserved codes 8 to 14 disable thermometer mode, and no `sample_valid` pulse is produced.
- R4: A change of rate code during a running interval leaves that interval's length unchanged. If the code is cleared to 0, the interval still ends with its pulse and its flag update, then analog mode takes over on the next edge. If the code becomes another valid code, that code governs the following interval.
- R5: In thermometer mode, a flag that is clear becomes set on a pulse when the sampled temperature is greater than or equal to its threshold. Each of the three flags uses its own threshold.
- R6: A flag that is set stays set on a pulse while temperature + hysteresis amount >= threshold. It clears when that sum is below the threshold. A hysteresis amount of 0 adds no offset.
- R7: In thermometer mode, the flags change only at the edge where `sample_valid` rises. A temperature change between pulses has no effect until the next pulse.
- R8: In analog mode with the sensor enabled, the flags follow the comparator bit one cycle later. With `comp_sel`=0, `trip_cat` equals `comp_in` and `trip_hot` is 0. With `comp_sel`=1, `trip_hot` equals `comp_in` and `trip_cat` is 0. `trip_aux` is always 0 in this mode.
- R9: With `sensor_en` low, all flags clear at the next edge, no pulse is produced, and the interval timer restarts from zero when the enable returns.
- R10: After synchronous reset, `sample_valid` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (memory clock domain) |
| rst | input | 1 | Synchronous active-high reset |
| sensor_en | input | 1 | Sensor power enable; low clears flags and stops the timer |
| rate_code | input | 4 | Interval select; 0 or a reserved code selects analog mode |
| hyst_amt | input | HYST_W (4) | Hysteresis in temperature LSBs, applied to flags that are set |
| thr_cat | input | TEMP_W (8) | Catastrophic threshold |
| thr_hot | input | TEMP_W (8) | Hot threshold |
| thr_aux | input | TEMP_W (8) | Auxiliary threshold |
| temp_code | input | TEMP_W (8) | Digital temperature sample |
| comp_in | input | 1 | Analog comparator result |
| comp_sel | input | 1 | Analog routing: 0 = catastrophic, 1 = hot |
| sample_valid | output | 1 | One-cycle pulse at the end of each interval |
| trip_cat | output | 1 | Catastrophic trip flag |
| trip_hot | output | 1 | Hot trip flag |
| trip_aux | output | 1 | Auxiliary trip flag |

## Verification
The bench measures every interval length edge by edge, so a design with an off-by-one count or an entry missing from the rate table reports a wrong cycle count. It clears the rate code and changes it to a new value partway through an interval. A design that aborted the interval, or reloaded the period early, would pulse at the wrong time, and a design that switched to analog too soon would show the comparator bit before the final pulse. It steps the temperature down through the hysteresis band one LSB at a time, so a design that applied the offset with the wrong sign or the wrong bound would clear the flag one step early or late. It also changes the temperature between pulses, and a flag that moved before the pulse exposes a design that does not hold its flags.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;

    localparam int RATE_W    = 4;
    localparam int NUM_TRIPS = 3;

    // Flag positions inside the trip vector
    localparam int IDX_CAT = 0;
    localparam int IDX_HOT = 1;
    localparam int IDX_AUX = 2;

    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    // How the flag registers are updated in a given cycle
    typedef struct packed {
        logic clear;   // sensor disabled
        logic sample;  // end of a thermometer interval
        logic load;    // analog mode direct load
    } flag_ctl_t;

    // Interval length in clocks for a rate code, 0 when the code selects no interval
    function automatic int unsigned period_of(logic [RATE_W-1:0] code,
                                              int unsigned base,
                                              int unsigned test);
        case (code)
            4'd1:    return base;
            4'd2:    return 2 * base;
            4'd3:    return 3 * base;
            4'd4:    return 4 * base;
            4'd5:    return 6 * base;
            4'd6:    return 8 * base;
            4'd7:    return 12 * base;
            4'd15:   return test;
            default: return 0;
        endcase
    endfunction

    function automatic logic rate_active(logic [RATE_W-1:0] code);
        return period_of(code, 1, 1) != 0;
    endfunction

endpackage

// File: rtl/trip_interval_timer.sv
module trip_interval_timer
    import thermal_trip_pkg::*;
#(
    parameter int BASE_CLKS = 512,
    parameter int TEST_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate_code,
    output logic              fire,
    output logic              tick,
    output logic              busy
);

    localparam int CNT_W = $clog2(BASE_CLKS * 12 + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] new_period;

    assign new_period = CNT_W'(period_of(rate_code, BASE_CLKS, TEST_CLKS));
    assign busy       = (state_q == TMR_RUN);
    assign fire       = enable && busy && (cnt_q == period_q - ONE);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q  <= TMR_IDLE;
            cnt_q    <= '0;
            period_q <= '0;
            tick     <= 1'b0;
        end else begin
            tick <= fire;
            case (state_q)
                TMR_IDLE: begin
                    cnt_q <= '0;
                    if (new_period != '0) begin
                        state_q  <= TMR_RUN;
                        period_q <= new_period;
                    end
                end
                TMR_RUN: begin
                    if (fire) begin
                        cnt_q <= '0;
                        if (new_period != '0) begin
                            period_q <= new_period;
                        end else begin
                            state_q  <= TMR_IDLE;
                            period_q <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                default: state_q <= TMR_IDLE;
            endcase
        end
    end

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R1
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q < period_q));

    // R9
    disable_stops_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !tick));

endmodule

// File: rtl/trip_comparator.sv
module trip_comparator
    import thermal_trip_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int HYST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  flag_ctl_t         ctl,
    input  logic              load_val,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] thresh,
    input  logic [HYST_W-1:0] hyst,
    output logic              trip
);

    localparam int EXT_W = TEMP_W + 1;

    logic [EXT_W-1:0] temp_ext;
    logic [EXT_W-1:0] thr_ext;
    logic [EXT_W-1:0] temp_plus_hyst;
    logic             set_cond;
    logic             hold_cond;
    logic             trip_next;

    assign temp_ext       = {1'b0, temp};
    assign thr_ext        = {1'b0, thresh};
    assign temp_plus_hyst = temp_ext + EXT_W'(hyst);
    assign set_cond       = temp_ext >= thr_ext;
    assign hold_cond      = temp_plus_hyst >= thr_ext;
    assign trip_next      = trip ? hold_cond : set_cond;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            trip <= 1'b0;
        end else if (ctl.sample) begin
            trip <= trip_next;
        end else if (ctl.load) begin
            trip <= load_val;
        end
    end

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.sample && !ctl.load && !ctl.clear) |=> $stable(trip));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> !trip);

endmodule

// File: rtl/thermal_trip_ctrl.sv
module thermal_trip_ctrl
    import thermal_trip_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int HYST_W    = 4,
    parameter int BASE_CLKS = 512,
    parameter int TEST_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sensor_en,
    input  logic [RATE_W-1:0] rate_code,
    input  logic [HYST_W-1:0] hyst_amt,
    input  logic [TEMP_W-1:0] thr_cat,
    input  logic [TEMP_W-1:0] thr_hot,
    input  logic [TEMP_W-1:0] thr_aux,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              comp_in,
    input  logic              comp_sel,
    output logic              sample_valid,
    output logic              trip_cat,
    output logic              trip_hot,
    output logic              trip_aux
);

    logic                 tmr_fire;
    logic                 tmr_busy;
    logic                 analog_now;
    flag_ctl_t            ctl;
    logic [TEMP_W-1:0]    thr_arr   [NUM_TRIPS];
    logic [NUM_TRIPS-1:0] analog_val;
    logic [NUM_TRIPS-1:0] trip_q;

    trip_interval_timer #(
        .BASE_CLKS(BASE_CLKS),
        .TEST_CLKS(TEST_CLKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .enable   (sensor_en),
        .rate_code(rate_code),
        .fire     (tmr_fire),
        .tick     (sample_valid),
        .busy     (tmr_busy)
    );

    // Analog mode only once no thermometer interval is running or about to start
    assign analog_now = sensor_en && !tmr_busy && !rate_active(rate_code);

    always_comb begin
        ctl.clear  = !sensor_en;
        ctl.sample = tmr_fire;
        ctl.load   = analog_now;
    end

    assign thr_arr[IDX_CAT] = thr_cat;
    assign thr_arr[IDX_HOT] = thr_hot;
    assign thr_arr[IDX_AUX] = thr_aux;

    assign analog_val[IDX_CAT] = comp_in && !comp_sel;
    assign analog_val[IDX_HOT] = comp_in && comp_sel;
    assign analog_val[IDX_AUX] = 1'b0;

    for (genvar g = 0; g < NUM_TRIPS; g++) begin : g_trip
        trip_comparator #(
            .TEMP_W(TEMP_W),
            .HYST_W(HYST_W)
        ) u_cmp (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .load_val(analog_val[g]),
            .temp    (temp_code),
            .thresh  (thr_arr[g]),
            .hyst    (hyst_amt),
            .trip    (trip_q[g])
        );
    end

    assign trip_cat = trip_q[IDX_CAT];
    assign trip_hot = trip_q[IDX_HOT];
    assign trip_aux = trip_q[IDX_AUX];

    // R8
    analog_aux_off_chk: assert property (@(posedge clk) disable iff (rst)
        analog_now |=> !trip_aux);

    // R3
    analog_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (analog_now && !rate_active(rate_code)) |=> !sample_valid);

endmodule

// File: tb/thermal_trip_ctrl_test.sv
module thermal_trip_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       sensor_en;
    logic [3:0] rate_code;
    logic [3:0] hyst_amt;
    logic [7:0] thr_cat, thr_hot, thr_aux, temp_code;
    logic       comp_in, comp_sel;
    logic       sample_valid, trip_cat, trip_hot, trip_aux;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    thermal_trip_ctrl uut (
        .clk(clk), .rst(rst), .sensor_en(sensor_en), .rate_code(rate_code),
        .hyst_amt(hyst_amt), .thr_cat(thr_cat), .thr_hot(thr_hot), .thr_aux(thr_aux),
        .temp_code(temp_code), .comp_in(comp_in), .comp_sel(comp_sel),
        .sample_valid(sample_valid), .trip_cat(trip_cat), .trip_hot(trip_hot),
        .trip_aux(trip_aux)
    );

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_pulse(int limit, output int n);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!sample_valid && n < limit);
    endtask

    task automatic count_pulses(int edges, output int c);
        c = 0;
        for (int i = 0; i < edges; i++) begin
            step(1);
            if (sample_valid) c++;
        end
    endtask

    task automatic restart(logic [3:0] code);
        sensor_en = 1'b0;
        step(1);
        rate_code = code;
        sensor_en = 1'b1;
    endtask

    function automatic int period_for(int code);
        case (code)
            1: return 512;
            2: return 1024;
            3: return 1536;
            4: return 2048;
            5: return 3072;
            6: return 4096;
            7: return 6144;
            15: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic t_reset();
        check("R10", "sample_valid after reset", int'(sample_valid), 0);
        check("R10", "flags after reset", int'({trip_cat, trip_hot, trip_aux}), 0);
    endtask

    task automatic t_rates();
        int n;
        int codes[8] = '{1, 2, 3, 4, 5, 6, 7, 15};
        thr_cat = 8'hFF; thr_hot = 8'hFF; thr_aux = 8'hFF; temp_code = 8'd0;
        foreach (codes[i]) begin
            int p = period_for(codes[i]);
            string rq = (codes[i] == 15) ? "R2" : "R1";
            restart(4'(codes[i]));
            wait_pulse(7000, n);
            check(rq, $sformatf("first pulse edges code %0d", codes[i]), n, p + 1);
            step(1);
            check(rq, "pulse lasts one cycle", int'(sample_valid), 0);
            wait_pulse(7000, n);
            check(rq, $sformatf("interval code %0d", codes[i]), n + 1, p);
        end
    endtask

    task automatic t_reserved();
        int c;
        int codes[4] = '{0, 8, 11, 14};
        foreach (codes[i]) begin
            restart(4'(codes[i]));
            count_pulses(700, c);
            check("R3", $sformatf("pulses with code %0d", codes[i]), c, 0);
        end
    endtask

    task automatic t_midcycle();
        int n;
        int c;
        thr_cat = 8'hFF; thr_hot = 8'hFF; thr_aux = 8'hFF; temp_code = 8'd0;
        comp_sel = 1'b0; comp_in = 1'b1;
        // clear the code mid-interval
        restart(4'd1);
        step(100);
        rate_code = 4'd0;
        wait_pulse(2000, n);
        check("R4", "stop: remaining interval", n, 413);
        check("R4", "stop: cat flag still thermometer at final pulse", int'(trip_cat), 0);
        step(1);
        check("R4", "stop: analog takes over next edge", int'(trip_cat), 1);
        count_pulses(1200, c);
        check("R4", "stop: no further pulses", c, 0);
        comp_in = 1'b0;
        // switch to another valid code mid-interval
        restart(4'd1);
        step(100);
        rate_code = 4'd15;
        wait_pulse(2000, n);
        check("R4", "switch: current interval kept", n, 413);
        wait_pulse(2000, n);
        check("R4", "switch: new interval applied", n, 4);
    endtask

    task automatic t_trip_basic();
        int n;
        thr_cat = 8'd100; thr_hot = 8'd80; thr_aux = 8'd60; hyst_amt = 4'd0;
        temp_code = 8'd10;
        restart(4'd15);
        wait_pulse(100, n);
        temp_code = 8'd70;
        wait_pulse(100, n);
        check("R5", "70: cat,hot,aux", int'({trip_cat, trip_hot, trip_aux}), 3'b001);
        temp_code = 8'd80;
        wait_pulse(100, n);
        check("R5", "80 equals hot threshold", int'({trip_cat, trip_hot, trip_aux}), 3'b011);
        temp_code = 8'd100;
        wait_pulse(100, n);
        check("R5", "100: all set", int'({trip_cat, trip_hot, trip_aux}), 3'b111);
        temp_code = 8'd99;
        wait_pulse(100, n);
        check("R6", "hyst 0: 99 clears cat", int'({trip_cat, trip_hot, trip_aux}), 3'b011);
    endtask

    task automatic t_hyst();
        int n;
        thr_cat = 8'd200; thr_hot = 8'd80; thr_aux = 8'd250; hyst_amt = 4'd6;
        temp_code = 8'd80;
        restart(4'd15);
        wait_pulse(100, n);
        check("R6", "80 sets hot", int'(trip_hot), 1);
        temp_code = 8'd75;
        wait_pulse(100, n);
        check("R6", "75 keeps hot", int'(trip_hot), 1);
        temp_code = 8'd74;
        wait_pulse(100, n);
        check("R6", "74 keeps hot (74+6=80)", int'(trip_hot), 1);
        temp_code = 8'd73;
        wait_pulse(100, n);
        check("R6", "73 clears hot", int'(trip_hot), 0);
        temp_code = 8'd77;
        wait_pulse(100, n);
        check("R6", "77 does not set from clear", int'(trip_hot), 0);
    endtask

    task automatic t_hold();
        int n;
        int moved = 0;
        thr_cat = 8'hFF; thr_hot = 8'd80; thr_aux = 8'hFF; hyst_amt = 4'd0;
        temp_code = 8'd50;
        restart(4'd1);
        wait_pulse(1000, n);
        check("R7", "hot clear after first pulse", int'(trip_hot), 0);
        temp_code = 8'd90;
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (trip_hot) moved++;
        end
        check("R7", "no flag change between pulses", moved, 0);
        wait_pulse(1000, n);
        check("R7", "hot set at next pulse", int'(trip_hot), 1);
    endtask

    task automatic t_analog();
        thr_cat = 8'd0; thr_hot = 8'd0; thr_aux = 8'd0; temp_code = 8'd200;
        comp_in = 1'b0; comp_sel = 1'b0;
        restart(4'd0);
        step(2);
        comp_in = 1'b1;
        step(1);
        check("R8", "sel0: cat,hot,aux", int'({trip_cat, trip_hot, trip_aux}), 3'b100);
        comp_sel = 1'b1;
        step(1);
        check("R8", "sel1: cat,hot,aux", int'({trip_cat, trip_hot, trip_aux}), 3'b010);
        comp_in = 1'b0;
        step(1);
        check("R8", "comp low: flags", int'({trip_cat, trip_hot, trip_aux}), 3'b000);
        comp_sel = 1'b0;
    endtask

    task automatic t_disable();
        int n;
        int c;
        thr_cat = 8'd0; thr_hot = 8'd0; thr_aux = 8'd0; temp_code = 8'd5;
        hyst_amt = 4'd0;
        restart(4'd15);
        wait_pulse(100, n);
        check("R9", "flags set before disable", int'({trip_cat, trip_hot, trip_aux}), 3'b111);
        sensor_en = 1'b0;
        step(1);
        check("R9", "flags cleared by disable", int'({trip_cat, trip_hot, trip_aux}), 3'b000);
        count_pulses(20, c);
        check("R9", "no pulse while disabled", c, 0);
        sensor_en = 1'b1;
        wait_pulse(100, n);
        check("R9", "timer restarts on enable", n, 5);
    endtask

    initial begin
        rst = 1'b1; sensor_en = 1'b0; rate_code = 4'd0; hyst_amt = 4'd0;
        thr_cat = 8'd0; thr_hot = 8'd0; thr_aux = 8'd0; temp_code = 8'd0;
        comp_in = 1'b0; comp_sel = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_rates();
        t_reserved();
        t_midcycle();
        t_trip_basic();
        t_hyst();
        t_hold();
        t_analog();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(10 * 190000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule